// File: doc/BRIEF.md
# Cosine Carrier Lookup Generator

This block produces a periodic cosine carrier as a stream of 16-bit unsigned samples. A small table of cosine samples, computed while the design elaborates, is walked in index order by an address counter. A second counter holds each table entry for a fixed number of enabled clocks, so the carrier period is the entry count times the hold count. With the defaults (19 entries, 7 clocks each) one carrier period spans 133 clocks, which from an 80 MHz sample clock gives a carrier near 601.5 kHz, close to a 600 kHz target while keeping the table at 20 entries or fewer.

Samples use an offset code: zero amplitude sits at mid-scale, the positive peak at all ones. The output is registered, and a one-cycle strobe marks each clock in which a fresh table entry appears. A modulator or mixer downstream can either use the held value on every clock or sample on the strobe. Clearing the enable freezes the carrier phase, and resuming continues from the same point.

Top module: `cos_carrier_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sample_o` becomes 0 and `sample_vld_o` becomes 0.
- R2: The entry at index k holds the code floor(32767.5 * (1 + cos(2*pi*k/ENTRIES)) + 0.5), limited to 0..65535 (offset binary, mid-scale 32767.5 is zero). Entry 0 is therefore 65535.
- R3: Entries are presented in increasing index order, one after another, with no index skipped.
- R4: Each entry stays on `sample_o` for HOLD enabled clocks. `sample_vld_o` is high for exactly one cycle per entry, in the cycle the new entry first appears.
- R5: After index ENTRIES-1 the address returns to 0, so the full carrier period is ENTRIES*HOLD enabled clocks (133 with defaults).
- R6: A clock with `en` low does not advance the phase. In the following cycle `sample_vld_o` is 0 and `sample_o` is unchanged. Once `en` returns, the sequence continues from where it stopped.
- R7: After reset, the first enabled clock loads entry 0 (the positive peak), which appears on `sample_o` with `sample_vld_o` high one cycle later.
- R8: A reset applied in the middle of a run restarts the sequence at entry 0 with a fresh hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advances the carrier phase by one clock when high |
| sample_o | output | 16 | Registered carrier sample, offset binary |
| sample_vld_o | output | 1 | High for one cycle when a new entry appears on sample_o |

## Verification
A long stretch with the enable held high shows the plain sequence, the hold length, the wrap back to index 0 and the 133-clock period, and it confirms that every table value lies within one code of an ideal cosine. Randomly gapped enable patterns from a fixed seed separate a design that counts enabled clocks from one that counts every clock, and they expose a strobe or sample change that leaks through an idle cycle. Directed cases cover the value right after reset, the first peak, and a reset issued in the middle of a hold, which shows whether both counters restart.

// File: rtl/cos_carrier_pkg.sv
// Package: cos_carrier_pkg
// Elaboration-time helpers for the cosine carrier generator.
// Assumes the caller passes a word width of 2..31 and a positive entry count.
package cos_carrier_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Offset-binary cosine code for entry k of an n-entry table, w bits wide.
    function automatic int unsigned cos_code(input int k, input int n, input int w);
        real ang;
        real x2;
        real term;
        real sum;
        real scale;
        real v;
        ang = (2.0 * PI_R * k) / n;
        if (ang > PI_R) ang = ang - 2.0 * PI_R;
        x2   = ang * ang;
        term = 1.0;
        sum  = 1.0;
        for (int i = 1; i <= 20; i++) begin
            term = -term * x2 / ((2.0 * i - 1.0) * (2.0 * i));
            sum  = sum + term;
        end
        scale = ((2.0 ** w) - 1.0) / 2.0;
        v = scale * (1.0 + sum) + 0.5;
        if (v < 0.0) v = 0.0;
        if (v > 2.0 * scale) v = 2.0 * scale;
        return $rtoi(v);
    endfunction

endpackage

// File: rtl/cos_table_rom.sv
// Module: cos_table_rom
// Constant cosine table, filled from cos_code at elaboration, read
// combinationally. Assumes addr_i is always below ENTRIES.
module cos_table_rom #(
    parameter int ENTRIES = 19,
    parameter int WIDTH   = 16,
    parameter int AW      = 5
) (
    input  logic [AW-1:0]    addr_i,
    output logic [WIDTH-1:0] data_o
);
    import cos_carrier_pkg::*;

    logic [WIDTH-1:0] tbl [ENTRIES];

    // One constant word per entry.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
        localparam int unsigned CODE = cos_code(k, ENTRIES, WIDTH);
        assign tbl[k] = CODE[WIDTH-1:0];
    end

    // Combinational read of the addressed entry.
    always_comb begin
        data_o = tbl[addr_i];
    end

endmodule

// File: rtl/cos_step_ctrl.sv
// Module: cos_step_ctrl
// Hold counter and table address counter. The address steps once every
// HOLD enabled clocks and wraps after ENTRIES-1. load_o marks the enabled
// clock in which the current address starts its hold.
// Assumes ENTRIES >= 2 and HOLD >= 1; synchronous active-low reset.
module cos_step_ctrl #(
    parameter int ENTRIES = 19,
    parameter int HOLD    = 7,
    parameter int AW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic          load_o,
    output logic [AW-1:0] addr_o
);
    localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD - 1);
    localparam logic [AW-1:0] ADDR_LAST = AW'(ENTRIES - 1);

    logic [HW-1:0] hold_q;
    logic [AW-1:0] addr_q;

    // Advance hold count; on its last clock step the address with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            addr_q <= '0;
        end else if (en) begin
            if (hold_q == HOLD_LAST) begin
                hold_q <= '0;
                addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    // A new entry is taken on the first enabled clock of its hold.
    always_comb begin
        load_o = en && (hold_q == '0);
        addr_o = addr_q;
    end

    // R5
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(addr_q) < ENTRIES);

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hold_q == HOLD_LAST && addr_q == ADDR_LAST) |=> (addr_q == '0));

    // R6
    phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(addr_q) && $stable(hold_q)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hold_q == HOLD_LAST && addr_q != ADDR_LAST) |=> (addr_q == $past(addr_q) + 1'b1));

    if (HOLD > 1) begin : g_multi
        // R4
        single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_o |=> !load_o);
    end

endmodule

// File: rtl/cos_carrier_gen.sv
// Module: cos_carrier_gen
// Top of the cosine carrier generator: step control, constant table and
// the registered sample output with its new-entry strobe.
// Assumes a free-running clock; rst_n is synchronous and active low.
module cos_carrier_gen #(
    parameter int ENTRIES = 19,
    parameter int HOLD    = 7,
    parameter int WIDTH   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] sample_o,
    output logic             sample_vld_o
);
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             load;
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] rom_data;

    cos_step_ctrl #(
        .ENTRIES (ENTRIES),
        .HOLD    (HOLD),
        .AW      (AW)
    ) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .load_o (load),
        .addr_o (addr)
    );

    cos_table_rom #(
        .ENTRIES (ENTRIES),
        .WIDTH   (WIDTH),
        .AW      (AW)
    ) rom_i (
        .addr_i (addr),
        .data_o (rom_data)
    );

    // Register the table word on a load and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o     <= '0;
            sample_vld_o <= 1'b0;
        end else begin
            sample_vld_o <= load;
            if (load) sample_o <= rom_data;
        end
    end

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sample_vld_o && $stable(sample_o)));

    // R4
    strobe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> $past(en));

    // R4
    held_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld_o && $past(rst_n)) |-> $stable(sample_o));

endmodule

// File: tb/cos_carrier_gen_tb.sv
// Bench: cos_carrier_gen_tb_top
// Reference model of the requirements, per-cycle comparison at the
// falling edge, fixed-seed random enable gaps plus directed corner cases.
module cos_carrier_gen_tb_top;
    localparam int ENTRIES = 19;
    localparam int HOLD    = 7;
    localparam int WIDTH   = 16;
    localparam real PI_R   = 3.14159265358979323846;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [WIDTH-1:0] sample_o;
    logic             sample_vld_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int cyc_n = 0;

    // model state
    int m_addr = 0;
    int m_hold = 0;
    int m_sample = 0;
    bit m_valid = 0;
    int m_loaded_addr = -1;

    always #5 clk = ~clk;

    cos_carrier_gen #(.ENTRIES(ENTRIES), .HOLD(HOLD), .WIDTH(WIDTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .sample_o     (sample_o),
        .sample_vld_o (sample_vld_o)
    );

    function automatic int ideal_code(input int k);
        real v;
        v = 32767.5 * (1.0 + $cos(2.0 * PI_R * k / ENTRIES)) + 0.5;
        if (v > 65535.0) v = 65535.0;
        if (v < 0.0) v = 0.0;
        return $rtoi(v);
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc_n, act, exp);
        end
    endtask

    // Advance the model by one clock edge with the given inputs.
    task automatic model_step(input bit e, input bit r);
        if (!r) begin
            m_addr = 0; m_hold = 0; m_sample = 0; m_valid = 0; m_loaded_addr = -1;
        end else if (e) begin
            if (m_hold == 0) begin
                m_sample = ideal_code(m_addr);
                m_loaded_addr = m_addr;
                m_valid = 1;
            end else begin
                m_valid = 0;
            end
            if (m_hold == HOLD - 1) begin
                m_hold = 0;
                m_addr = (m_addr + 1) % ENTRIES;
            end else begin
                m_hold++;
            end
        end else begin
            m_valid = 0;
        end
    endtask

    // Drive one cycle from a falling edge and compare at the next one.
    task automatic cycle(input bit e, input bit r, input string tag);
        en = e;
        rst_n = r;
        model_step(e, r);
        @(negedge clk);
        cyc_n++;
        check({tag, " strobe"}, sample_vld_o == m_valid, int'(sample_vld_o), int'(m_valid));
        check({tag, " sample"}, absdiff(int'(sample_o), m_sample) <= 1, int'(sample_o), m_sample);
    endtask

    initial begin
        int last_peak;
        int seen_first;
        int unsigned seed;
        seed = 32'd20240917;
        void'($urandom(seed));
        @(negedge clk);

        // R1: reset state
        repeat (3) cycle(1'b0, 1'b0, "R1");
        check("R1 reset sample zero", sample_o == '0, int'(sample_o), 0);
        check("R1 reset strobe low", sample_vld_o == 1'b0, int'(sample_vld_o), 0);

        // R7: first enabled clock gives entry 0 (peak) one cycle later
        cycle(1'b1, 1'b1, "R7");
        check("R7 first strobe", sample_vld_o == 1'b1, int'(sample_vld_o), 1);
        check("R7 first is peak", sample_o == 16'hFFFF, int'(sample_o), 65535);

        // R3 R4 R5: continuous run over more than two periods
        last_peak = cyc_n;
        seen_first = 0;
        for (int i = 0; i < 3 * ENTRIES * HOLD; i++) begin
            cycle(1'b1, 1'b1, "R3_R4");
            if (sample_vld_o && sample_o == 16'hFFFF) begin
                check("R5 period", cyc_n - last_peak == ENTRIES * HOLD, cyc_n - last_peak, ENTRIES * HOLD);
                last_peak = cyc_n;
            end
            if (sample_vld_o && m_loaded_addr == 0) seen_first++;
        end
        check("R5 wrapped to entry 0", seen_first == 3, seen_first, 3);

        // R2: exact codes at the extremes of the default table
        for (int k = 0; k < ENTRIES; k++) begin
            // walk until entry k is freshly loaded
            for (int w = 0; w < ENTRIES * HOLD + 1; w++) begin
                cycle(1'b1, 1'b1, "R2_walk");
                if (sample_vld_o && m_loaded_addr == k) break;
            end
            check("R2 table code", absdiff(int'(sample_o), ideal_code(k)) <= 1, int'(sample_o), ideal_code(k));
            if (k == 9 || k == 10)
                check("R2 trough symmetric", absdiff(int'(sample_o), ideal_code(ENTRIES - k)) <= 1,
                      int'(sample_o), ideal_code(ENTRIES - k));
        end

        // R6: random enable gaps
        for (int i = 0; i < 4000; i++) begin
            cycle(($urandom % 100) < 65, 1'b1, "R6");
        end
        // R6: long idle stretch keeps everything
        repeat (25) cycle(1'b0, 1'b1, "R6_idle");

        // R8: reset in the middle of a hold
        repeat (HOLD + 3) cycle(1'b1, 1'b1, "R8_pre");
        cycle(1'b1, 1'b0, "R8_rst");
        check("R8 reset clears strobe", sample_vld_o == 1'b0, int'(sample_vld_o), 0);
        cycle(1'b1, 1'b1, "R8_restart");
        check("R8 restart at peak", sample_o == 16'hFFFF && sample_vld_o, int'(sample_o), 65535);
        for (int i = 0; i < 2 * HOLD; i++) cycle(1'b1, 1'b1, "R8_follow");

        // random run with sporadic resets
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 100) < 80, ($urandom % 500) != 0, "R8_mix");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired cycle=%0d actual=running expected=finished", cyc_n);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule